// File: doc/BRIEF.md
# Secure Mode Tracker and Region Access Checker

This block tracks the security mode of one process on a single-chip secure processor and judges every load, store and instruction fetch against four programmable protected address windows. It has four states: standard (`ST_STD`), hash pending (`ST_HASH`), secure (`ST_SEC`) and suspended (`ST_SUSP`). The transitions are as follows. `ST_STD` goes to `ST_HASH` on `enter_req`, and the block raises `hash_start` toward the hash engine. `ST_HASH` goes to `ST_SEC` on `hash_done`. `ST_SEC` goes to `ST_SUSP` on `suspend_req`. `ST_SUSP` goes back to `ST_SEC` only on a `resume_req` whose `resume_pc` equals the registered entry address. A resume to any other PC pulses `resume_fault` and leaves the state as it is. While the hash is pending, the visible mode is still standard.

Each window is an inclusive base/limit pair. The four window kinds are static verified, static encrypted, dynamic verified and dynamic encrypted. An address that falls in no window is unprotected. Each access with a valid strobe produces a registered response one cycle later. The response carries grant or fault, and the off-chip protections the access needs: integrity verification and encryption. It also carries an authenticated-code flag for fetches. The cryptographic engines and the hash engine sit outside the block. The block only exchanges start, done and fault handshakes with them.

Top module: `secmode_guard`

## Requirements
- R1: After synchronous reset, `mode` is standard (2'b00), `hash_pending`, `hash_start`, `resume_fault` and `rsp_valid` are low, and the registered entry address is zero.
- R2: `enter_req` in standard mode pulses `hash_start` for exactly one cycle and raises `hash_pending`. `mode` stays standard until `hash_done`, and reads secure (2'b01) from the edge after `hash_done`.
- R3: In secure mode, an access to a protected window is granted with `rsp_needs_iv`=1. `rsp_needs_enc`=1 only for the encrypted kinds. The window select codes are 0 static verified, 1 static encrypted, 2 dynamic verified and 3 dynamic encrypted.
- R4: A store (`acc_kind`=2'b01) to a static window faults in every mode.
- R5: In standard mode, hash-pending mode and suspended mode, any protected access faults. Unprotected accesses are granted in every mode, with both protection flags low.
- R6: Where windows overlap, the winner is, in order, dynamic encrypted, static encrypted, dynamic verified, then static verified.
- R7: `suspend_req` in secure mode moves `mode` to suspended (2'b10) at the next edge.
- R8: `resume_req` in suspended mode with `resume_pc` equal to the entry address returns to secure mode. Any other PC pulses `resume_fault` for one cycle and the mode stays suspended.
- R9: `entry_we` loads the entry address only in secure mode. Writes in any other mode are ignored.
- R10: `rsp_auth` is high only for a granted fetch (`acc_kind`=2'b10) from a protected window in secure mode. An unprotected fetch is never authenticated.
- R11: `rsp_valid` is high exactly one cycle after `acc_valid`, and then exactly one of `rsp_grant`/`rsp_fault` is high. On a fault, all flags are low.
- R12: Window bounds are inclusive: the addresses `base` and `limit` hit, and `base-1` and `limit+1` do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write one window's bounds |
| cfg_sel | input | 2 | Window kind written (0 SV, 1 SE, 2 DV, 3 DE) |
| cfg_base | input | ADDR_W | Lowest address of the window |
| cfg_limit | input | ADDR_W | Highest address of the window |
| enter_req | input | 1 | Request secure entry from standard mode |
| hash_done | input | 1 | Identity hash finished |
| suspend_req | input | 1 | Suspend secure processing |
| resume_req | input | 1 | Request resume of secure processing |
| resume_pc | input | ADDR_W | Target PC of the resume |
| entry_we | input | 1 | Register the resume entry address |
| entry_addr | input | ADDR_W | New resume entry address |
| acc_valid | input | 1 | Access request strobe |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| acc_addr | input | ADDR_W | Access address |
| mode | output | 2 | 0 standard, 1 secure, 2 suspended |
| hash_pending | output | 1 | Waiting for identity hash |
| hash_start | output | 1 | One-cycle start pulse to hash engine |
| resume_fault | output | 1 | One-cycle pulse on a bad resume |
| rsp_valid | output | 1 | Response valid |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access denied |
| rsp_needs_iv | output | 1 | Access needs integrity verification |
| rsp_needs_enc | output | 1 | Access needs encryption/decryption |
| rsp_auth | output | 1 | Fetch counts as authenticated code |

## Verification
The bench places accesses exactly on window edges. A design with exclusive bounds would fault or drop the flags at `limit`, and a design with loose bounds would protect `limit+1`. The bench probes protected windows while the hash is pending. A design that opens the windows at `enter_req` instead of at `hash_done` would grant those accesses. Overlapping windows test the priority order: a wrong order reports encryption as off for addresses that lie in an encrypted window. The bench resumes to a wrong PC, and also to an entry address that was written while suspended. A careless design would leave suspension in both cases or latch the ignored write.

// File: rtl/secg_pkg.sv
package secg_pkg;

    localparam int REGION_KINDS = 4;
    localparam int SEL_W        = $clog2(REGION_KINDS);

    localparam int KIND_SV = 0;
    localparam int KIND_SE = 1;
    localparam int KIND_DV = 2;
    localparam int KIND_DE = 3;

    typedef enum logic [1:0] {
        MODE_STD  = 2'b00,
        MODE_SEC  = 2'b01,
        MODE_SUSP = 2'b10
    } sec_mode_e;

    typedef enum logic [1:0] {
        ST_STD,
        ST_HASH,
        ST_SEC,
        ST_SUSP
    } fsm_state_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_kind_e;

    typedef struct packed {
        logic prot;
        logic is_static;
        logic enc;
    } region_attr_t;

endpackage

// File: rtl/secg_region_map.sv
module secg_region_map
    import secg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic [ADDR_W-1:0] addr,
    output region_attr_t      attr
);

    logic [ADDR_W-1:0]       base_q  [REGION_KINDS];
    logic [ADDR_W-1:0]       limit_q [REGION_KINDS];
    logic [REGION_KINDS-1:0] hit;

    for (genvar k = 0; k < REGION_KINDS; k++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[k]  <= '1;
                limit_q[k] <= '0;
            end else if (cfg_we && cfg_sel == SEL_W'(k)) begin
                base_q[k]  <= cfg_base;
                limit_q[k] <= cfg_limit;
            end
        end
        assign hit[k] = (addr >= base_q[k]) && (addr <= limit_q[k]);
    end

    // Lowest priority first; later matches override earlier ones.
    always_comb begin
        attr = '0;
        if (hit[KIND_SV]) attr = '{prot: 1'b1, is_static: 1'b1, enc: 1'b0};
        if (hit[KIND_DV]) attr = '{prot: 1'b1, is_static: 1'b0, enc: 1'b0};
        if (hit[KIND_SE]) attr = '{prot: 1'b1, is_static: 1'b1, enc: 1'b1};
        if (hit[KIND_DE]) attr = '{prot: 1'b1, is_static: 1'b0, enc: 1'b1};
    end

    AST_DYN_ENC_WINS: assert property (@(posedge clk) disable iff (rst)
        hit[KIND_DE] |-> (attr.enc && !attr.is_static)); // R6

endmodule

// File: rtl/secg_mode_fsm.sv
module secg_mode_fsm
    import secg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_req,
    input  logic              hash_done,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic [ADDR_W-1:0] resume_pc,
    input  logic              entry_we,
    input  logic [ADDR_W-1:0] entry_addr,
    output sec_mode_e         mode,
    output logic              hash_pending,
    output logic              hash_start,
    output logic              resume_fault
);

    fsm_state_e        state_q, state_d;
    logic [ADDR_W-1:0] entry_q;
    logic              pc_match;

    assign pc_match = (resume_pc == entry_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STD:  if (enter_req)              state_d = ST_HASH;
            ST_HASH: if (hash_done)              state_d = ST_SEC;
            ST_SEC:  if (suspend_req)            state_d = ST_SUSP;
            ST_SUSP: if (resume_req && pc_match) state_d = ST_SEC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_STD;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q      <= '0;
            hash_start   <= 1'b0;
            resume_fault <= 1'b0;
        end else begin
            hash_start   <= (state_q == ST_STD) && enter_req;
            resume_fault <= (state_q == ST_SUSP) && resume_req && !pc_match;
            if (state_q == ST_SEC && entry_we) entry_q <= entry_addr;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_STD, ST_HASH: mode = MODE_STD;
            ST_SEC:          mode = MODE_SEC;
            ST_SUSP:         mode = MODE_SUSP;
        endcase
    end

    assign hash_pending = (state_q == ST_HASH);

    AST_HASH_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        hash_start |=> !hash_start); // R2
    AST_SUSP_FROM_SEC: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUSP && $past(state_q) != ST_SUSP) |-> $past(state_q) == ST_SEC); // R7
    AST_BAD_RESUME_STAYS: assert property (@(posedge clk) disable iff (rst)
        resume_fault |-> mode == MODE_SUSP); // R8
    AST_SEC_AFTER_HASH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEC && $past(state_q) != ST_SEC) |-> ($past(state_q) == ST_SUSP || $past(hash_done))); // R2

endmodule

// File: rtl/secg_access_check.sv
module secg_access_check
    import secg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         acc_valid,
    input  acc_kind_e    acc_kind,
    input  region_attr_t attr,
    input  sec_mode_e    mode,
    output logic         rsp_valid,
    output logic         rsp_grant,
    output logic         rsp_fault,
    output logic         rsp_needs_iv,
    output logic         rsp_needs_enc,
    output logic         rsp_auth
);

    logic mode_blocks;
    logic ro_violation;
    logic deny;

    assign mode_blocks  = attr.prot && (mode != MODE_SEC);
    assign ro_violation = attr.prot && attr.is_static && (acc_kind == ACC_STORE);
    assign deny         = mode_blocks || ro_violation;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_grant     <= 1'b0;
            rsp_fault     <= 1'b0;
            rsp_needs_iv  <= 1'b0;
            rsp_needs_enc <= 1'b0;
            rsp_auth      <= 1'b0;
        end else begin
            rsp_valid     <= acc_valid;
            rsp_grant     <= acc_valid && !deny;
            rsp_fault     <= acc_valid && deny;
            rsp_needs_iv  <= acc_valid && !deny && attr.prot;
            rsp_needs_enc <= acc_valid && !deny && attr.prot && attr.enc;
            rsp_auth      <= acc_valid && !deny && attr.prot && (acc_kind == ACC_FETCH);
        end
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_grant ^ rsp_fault)); // R11
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid); // R11
    AST_STATIC_STORE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_kind == ACC_STORE && attr.is_static) |=> rsp_fault); // R4
    AST_PROT_NEEDS_SEC: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && attr.prot && mode != MODE_SEC) |=> rsp_fault); // R5
    AST_ENC_IMPLIES_IV: assert property (@(posedge clk) disable iff (rst)
        rsp_needs_enc |-> rsp_needs_iv); // R3

endmodule

// File: rtl/secmode_guard.sv
module secmode_guard
    import secg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic              enter_req,
    input  logic              hash_done,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic [ADDR_W-1:0] resume_pc,
    input  logic              entry_we,
    input  logic [ADDR_W-1:0] entry_addr,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [1:0]        mode,
    output logic              hash_pending,
    output logic              hash_start,
    output logic              resume_fault,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_fault,
    output logic              rsp_needs_iv,
    output logic              rsp_needs_enc,
    output logic              rsp_auth
);

    region_attr_t attr;
    sec_mode_e    cur_mode;

    secg_region_map #(.ADDR_W(ADDR_W)) u_map (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_base  (cfg_base),
        .cfg_limit (cfg_limit),
        .addr      (acc_addr),
        .attr      (attr)
    );

    secg_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .enter_req    (enter_req),
        .hash_done    (hash_done),
        .suspend_req  (suspend_req),
        .resume_req   (resume_req),
        .resume_pc    (resume_pc),
        .entry_we     (entry_we),
        .entry_addr   (entry_addr),
        .mode         (cur_mode),
        .hash_pending (hash_pending),
        .hash_start   (hash_start),
        .resume_fault (resume_fault)
    );

    secg_access_check u_chk (
        .clk           (clk),
        .rst           (rst),
        .acc_valid     (acc_valid),
        .acc_kind      (acc_kind_e'(acc_kind)),
        .attr          (attr),
        .mode          (cur_mode),
        .rsp_valid     (rsp_valid),
        .rsp_grant     (rsp_grant),
        .rsp_fault     (rsp_fault),
        .rsp_needs_iv  (rsp_needs_iv),
        .rsp_needs_enc (rsp_needs_enc),
        .rsp_auth      (rsp_auth)
    );

    assign mode = cur_mode;

endmodule

// File: tb/tb_secmode_guard.sv
module tb_secmode_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_base = '0, cfg_limit = '0;
    logic        enter_req = 1'b0, hash_done = 1'b0, suspend_req = 1'b0, resume_req = 1'b0;
    logic [31:0] resume_pc = '0;
    logic        entry_we = 1'b0;
    logic [31:0] entry_addr = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  mode;
    logic        hash_pending, hash_start, resume_fault;
    logic        rsp_valid, rsp_grant, rsp_fault, rsp_needs_iv, rsp_needs_enc, rsp_auth;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    // expected {grant, iv, enc, auth}
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    secmode_guard dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // monitor: pop and compare responses
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected response", 32'(rsp_valid), 32'd0);
            end else begin
                logic [3:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({rsp_grant, rsp_needs_iv, rsp_needs_enc, rsp_auth} == e, t,
                    32'({rsp_grant, rsp_needs_iv, rsp_needs_enc, rsp_auth}), 32'(e));
                chk(rsp_fault == !rsp_grant, "R11 verdict", 32'(rsp_fault), 32'(!rsp_grant));
            end
        end
    end

    // driver: queue expectation, present request for one cycle
    task automatic access(input logic [1:0] kind, input logic [31:0] a,
                          input logic g, input logic iv, input logic enc, input logic au,
                          input string tag);
        @(negedge clk);
        exp_q.push_back({g, iv, enc, au});
        tag_q.push_back(tag);
        acc_valid = 1'b1; acc_kind = kind; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic set_win(input logic [1:0] sel, input logic [31:0] b, input logic [31:0] l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_base = b; cfg_limit = l;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic suspend();
        @(negedge clk); suspend_req = 1'b1;
        @(negedge clk); suspend_req = 1'b0;
        chk(mode == 2'b10, "R7 suspend", 32'(mode), 32'd2);
    endtask

    task automatic resume(input logic [31:0] pc, input bit good);
        @(negedge clk); resume_req = 1'b1; resume_pc = pc;
        @(negedge clk); resume_req = 1'b0;
        chk(mode == (good ? 2'b01 : 2'b10), "R8 resume mode", 32'(mode), good ? 32'd1 : 32'd2);
        chk(resume_fault == !good, "R8 resume fault", 32'(resume_fault), 32'(!good));
        if (!good) begin
            @(negedge clk);
            chk(resume_fault == 1'b0, "R8 fault one cycle", 32'(resume_fault), 32'd0);
        end
    endtask

    initial begin
        #(200000 * 10);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    localparam logic [1:0] LD = 2'b00, ST = 2'b01, FE = 2'b10;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(mode == 2'b00, "R1 mode", 32'(mode), 32'd0);
        chk(!hash_pending && !hash_start && !resume_fault && !rsp_valid, "R1 outputs",
            32'({hash_pending, hash_start, resume_fault, rsp_valid}), 32'd0);

        set_win(2'd0, 32'h1000, 32'h1FFF);
        set_win(2'd1, 32'h2000, 32'h2FFF);
        set_win(2'd2, 32'h3000, 32'h3FFF);
        set_win(2'd3, 32'h4000, 32'h4FFF);

        // standard mode
        access(LD, 32'h0100, 1, 0, 0, 0, "R5 std unprotected load");
        access(LD, 32'h1000, 0, 0, 0, 0, "R5 std protected load");
        access(FE, 32'h4000, 0, 0, 0, 0, "R5 std protected fetch");
        access(ST, 32'h1800, 0, 0, 0, 0, "R4 std static store");

        // secure entry via hash
        @(negedge clk); enter_req = 1'b1;
        @(negedge clk); enter_req = 1'b0;
        chk(hash_start == 1'b1, "R2 hash_start pulse", 32'(hash_start), 32'd1);
        chk(hash_pending == 1'b1, "R2 hash_pending", 32'(hash_pending), 32'd1);
        chk(mode == 2'b00, "R2 mode while hashing", 32'(mode), 32'd0);
        @(negedge clk);
        chk(hash_start == 1'b0, "R2 hash_start one cycle", 32'(hash_start), 32'd0);
        access(LD, 32'h3000, 0, 0, 0, 0, "R5 protected while hash pending");
        @(negedge clk); hash_done = 1'b1;
        @(negedge clk); hash_done = 1'b0;
        chk(mode == 2'b01, "R2 secure after hash_done", 32'(mode), 32'd1);
        chk(hash_pending == 1'b0, "R2 pending cleared", 32'(hash_pending), 32'd0);

        // secure accesses
        access(LD, 32'h1000, 1, 1, 0, 0, "R3 R12 static verified base");
        access(LD, 32'h2000, 1, 1, 1, 0, "R3 static encrypted load");
        access(ST, 32'h3FFF, 1, 1, 0, 0, "R3 R12 dynamic verified limit store");
        access(ST, 32'h4000, 1, 1, 1, 0, "R3 dynamic encrypted store");
        access(ST, 32'h1FFF, 0, 0, 0, 0, "R4 secure static store");
        access(ST, 32'h2800, 0, 0, 0, 0, "R4 secure static enc store");
        access(LD, 32'h0FFF, 1, 0, 0, 0, "R12 base-1 unprotected");
        access(LD, 32'h5000, 1, 0, 0, 0, "R12 limit+1 unprotected");
        access(FE, 32'h1000, 1, 1, 0, 1, "R10 verified fetch authenticated");
        access(FE, 32'h0100, 1, 0, 0, 0, "R10 unprotected fetch not authenticated");

        // entry address cleared by reset
        suspend();
        resume(32'h0, 1'b1);

        @(negedge clk); entry_we = 1'b1; entry_addr = 32'h8000;
        @(negedge clk); entry_we = 1'b0;
        suspend();
        access(LD, 32'h2000, 0, 0, 0, 0, "R5 suspended protected load");
        access(FE, 32'h1000, 0, 0, 0, 0, "R5 R10 suspended fetch");
        access(LD, 32'h0100, 1, 0, 0, 0, "R5 suspended unprotected load");
        @(negedge clk); entry_we = 1'b1; entry_addr = 32'h9000;
        @(negedge clk); entry_we = 1'b0;
        resume(32'h9000, 1'b0);   // R9 write while suspended was ignored
        resume(32'h8004, 1'b0);   // R8 wrong pc
        resume(32'h8000, 1'b1);   // R8 R9 registered entry

        // overlap priority R6
        set_win(2'd2, 32'h3000, 32'h4FFF);
        set_win(2'd1, 32'h2000, 32'h3FFF);
        set_win(2'd0, 32'h1000, 32'h5FFF);
        access(LD, 32'h4800, 1, 1, 1, 0, "R6 dyn enc over dyn ver");
        access(ST, 32'h3800, 0, 0, 0, 0, "R6 static enc over dyn ver");
        access(LD, 32'h3800, 1, 1, 1, 0, "R6 static enc flags");
        access(ST, 32'h4F00, 1, 1, 1, 0, "R6 dyn enc over static ver");
        access(ST, 32'h5800, 0, 0, 0, 0, "R6 static ver only");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R11 missing responses", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule